// File: doc/BRIEF.md
# Signature-Gated Serial Configuration Register

This block takes configuration data one bit at a time, most significant bit first, into a shift chain. The host shifts in a payload byte and then a trailing 8-bit signature byte. The signature does two jobs. It checks that the stream is valid, and it selects a group of held configuration bits.

When the active-low write strobe rises, the signature in the chain is decoded. A recognised signature copies the payload byte into the holding register of its group only. The other groups keep their contents. An unrecognised signature loads nothing, but the shifted bits stay in the chain.

The raw chain stages are brought out as transient bits. The holding registers are the persistent bits. The last accepted signature and the end of the chain are also exported, so that the host can run a loopback check. Shifting is allowed only while the strobe is low.

Top module: `sig_cfg_reg`

## Requirements
- R1: While `rst` is high, every group register, `ctrl_q` and `chain_q` go to zero, and they stay zero on the first cycle after reset.
- R2: On a clock edge where `shift_en` is 1 and `wr_n` is 0, the chain shifts up by one. The previous bit 14 moves to bit 15 and `sdi` enters bit 0. After a payload byte and then a signature byte are shifted in MSB first, the signature sits in `chain_q[7:0]` and the payload sits in `chain_q[15:8]`.
- R3: On any clock edge where `wr_n` is 1, `shift_en` is ignored and `chain_q` keeps its value.
- R4: A write is the first clock edge that samples `wr_n` as 1 after it was 0. At a write, signature 0x54 loads `chain_q[15:8]` into group 0, which is `grp_q[7:0]`. Signature 0x43 loads group 1 (`grp_q[15:8]`), and signature 0x4D loads group 2 (`grp_q[23:16]`). The result is visible after that edge.
- R5: A write changes only the addressed group. The other groups keep their values.
- R6: At a write whose signature matches none of the three codes, no group changes and `ctrl_q` does not change. `chain_q` still holds the shifted data.
- R7: At a write with a recognised signature, `ctrl_q` takes that signature value.
- R8: A write decodes the chain as it stood before the strobe edge. A `shift_en` request on that same edge is dropped. While `wr_n` stays high, no further load takes place.
- R9: `tail_o` always equals `chain_q[15]`, the oldest bit in the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data in, most significant bit first |
| shift_en | input | 1 | Shift request for this clock cycle |
| wr_n | input | 1 | Active-low write strobe; its rising edge commits a write |
| grp_q | output | 24 | Persistent group registers; group i occupies bits 8i+7:8i |
| ctrl_q | output | 8 | Last signature that was accepted |
| chain_q | output | 16 | Raw shift chain (transient bits) |
| tail_o | output | 1 | Oldest chain bit, used for readback |

## Verification
A shift request and a write can fall on the same clock edge. The bench provokes this by raising `wr_n` while `shift_en` is high and `sdi` is 1. The check expects the addressed group to receive the payload byte as it stood before the edge. It also expects `chain_q` to be unchanged afterwards, which proves the shift was dropped. A behavioural bit-queue model follows every edge and compares all outputs once per cycle, which also covers strobes that are held high over several cycles and shifts that are attempted during them.

// File: rtl/sig_cfg_pkg.sv
package sig_cfg_pkg;
  localparam int SIG_W = 8;
  localparam int GRP_W = 8;
  localparam int NGRP  = 3;

  typedef logic [SIG_W-1:0] sig_t;

  // Code that selects group i
  function automatic sig_t grp_code(input int i);
    case (i)
      0:       grp_code = 8'h54;
      1:       grp_code = 8'h43;
      2:       grp_code = 8'h4D;
      default: grp_code = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sig_shift_chain.sv
module sig_shift_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         hold,
  input  logic         sdi,
  output logic [W-1:0] chain_q
);
  always_ff @(posedge clk) begin
    if (rst)
      chain_q <= '0;
    else if (shift_en && !hold)
      chain_q <= {chain_q[W-2:0], sdi};
  end

  // R3: strobe high freezes the chain
  a_r3_hold_chain: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(chain_q));

  // R2: new bit lands at the bottom
  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !hold) |=> (chain_q[0] == $past(sdi) && chain_q[W-1:1] == $past(chain_q[W-2:0])));
endmodule

// File: rtl/sig_decode.sv
module sig_decode
  import sig_cfg_pkg::*;
#(
  parameter int N = NGRP
) (
  input  sig_t         sig_i,
  output logic [N-1:0] sel_o,
  output logic         hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign sel_o[g] = (sig_i == grp_code(g));
  end
  assign hit_o = |sel_o;

  // R4: codes are distinct, so at most one group is addressed
  always_comb begin
    a_r4_onehot: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/sig_hold_bank.sv
module sig_hold_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load)
      q <= d;
  end

  // R5: persistent cell changes only when loaded
  a_r5_keep: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/sig_cfg_reg.sv
module sig_cfg_reg
  import sig_cfg_pkg::*;
#(
  parameter int GW = GRP_W,
  parameter int SW = SIG_W,
  parameter int NG = NGRP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdi,
  input  logic             shift_en,
  input  logic             wr_n,
  output logic [NG*GW-1:0] grp_q,
  output logic [SW-1:0]    ctrl_q,
  output logic [GW+SW-1:0] chain_q,
  output logic             tail_o
);
  localparam int CW = GW + SW;

  logic          wr_d;
  logic          wr_rise;
  logic [NG-1:0] sel;
  logic          hit;
  logic [SW-1:0] sig;
  logic [GW-1:0] payload;

  always_ff @(posedge clk) begin
    if (rst) wr_d <= 1'b1;
    else     wr_d <= wr_n;
  end
  assign wr_rise = wr_n && !wr_d;

  sig_shift_chain #(.W(CW)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .hold(wr_n),
    .sdi(sdi), .chain_q(chain_q)
  );

  assign sig     = chain_q[SW-1:0];
  assign payload = chain_q[CW-1:SW];
  assign tail_o  = chain_q[CW-1];

  sig_decode #(.N(NG)) u_dec (.sig_i(sig), .sel_o(sel), .hit_o(hit));

  for (genvar g = 0; g < NG; g++) begin : g_bank
    sig_hold_bank #(.W(GW)) u_bank (
      .clk(clk), .rst(rst), .load(wr_rise && sel[g]),
      .d(payload), .q(grp_q[g*GW +: GW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_rise && hit)
      ctrl_q <= sig;
  end

  // R6: unknown signature touches no persistent state
  a_r6_reject: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && !hit) |=> ($stable(grp_q) && $stable(ctrl_q)));

  // R7: accepted signature is latched for readback
  a_r7_ctrl: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && hit) |=> (ctrl_q == $past(sig)));

  // R8: a held strobe does not reload
  a_r8_level: assert property (@(posedge clk) disable iff (rst)
    (wr_n && wr_d) |=> ($stable(grp_q) && $stable(ctrl_q)));
endmodule

// File: tb/sim_sig_cfg_reg.sv
module sim_sig_cfg_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi = 1'b0, shift_en = 1'b0, wr_n = 1'b0;
  logic [23:0] grp_q;
  logic [7:0]  ctrl_q;
  logic [15:0] chain_q;
  logic        tail_o;

  int checks = 0, errors = 0;
  bit done = 0, started = 0;

  always #2.5 clk = ~clk;

  sig_cfg_reg u0 (.clk(clk), .rst(rst), .sdi(sdi), .shift_en(shift_en),
    .wr_n(wr_n), .grp_q(grp_q), .ctrl_q(ctrl_q), .chain_q(chain_q), .tail_o(tail_o));

  // Behavioural model: bit queue, newest at the back
  bit m_bits[$];
  int m_grp[3];
  int m_ctrl;
  bit m_wr_prev;

  function automatic int q_val(int from, int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | int'(m_bits[from + i]);
    return v;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_bits = {};
      for (int i = 0; i < 16; i++) m_bits.push_back(1'b0);
      foreach (m_grp[i]) m_grp[i] = 0;
      m_ctrl = 0;
      m_wr_prev = 1;
    end else begin
      if (wr_n && !m_wr_prev) begin
        int s, p, idx;
        s = q_val(8, 8); p = q_val(0, 8);
        idx = (s == 'h54) ? 0 : (s == 'h43) ? 1 : (s == 'h4D) ? 2 : -1;
        if (idx >= 0) begin m_grp[idx] = p; m_ctrl = s; end
      end
      if (shift_en && !wr_n) begin
        m_bits.push_back(sdi);
        void'(m_bits.pop_front());
      end
      m_wr_prev = wr_n;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk("R2 chain", int'(chain_q), q_val(0, 16));
    chk("R4 group0", int'(grp_q[7:0]), m_grp[0]);
    chk("R4 group1", int'(grp_q[15:8]), m_grp[1]);
    chk("R4 group2", int'(grp_q[23:16]), m_grp[2]);
    chk("R7 ctrl", int'(ctrl_q), m_ctrl);
    chk("R9 tail", int'(tail_o), int'(m_bits[0]));
  end

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i]; shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  task automatic strobe();
    wr_n = 1'b1; @(negedge clk); @(negedge clk);
    wr_n = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset grp", int'(grp_q), 0);
    chk("R1 reset ctrl", int'(ctrl_q), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset chain", int'(chain_q), 0);

    send_byte(8'hFF); send_byte(8'h54);
    chk("R2 layout", int'(chain_q), 'hFF54);
    strobe();
    chk("R4 T group", int'(grp_q[7:0]), 'hFF);
    chk("R5 others kept", int'(grp_q[23:8]), 0);
    chk("R7 ctrl T", int'(ctrl_q), 'h54);

    send_byte(8'hA5); send_byte(8'h43); strobe();
    chk("R4 C group", int'(grp_q[15:8]), 'hA5);
    chk("R5 T kept", int'(grp_q[7:0]), 'hFF);

    send_byte(8'h3C); send_byte(8'h5A); strobe();
    chk("R6 groups kept", int'(grp_q), 'h00A5FF);
    chk("R6 ctrl kept", int'(ctrl_q), 'h43);
    chk("R6 chain kept", int'(chain_q), 'h3C5A);

    // R3: shift requests while strobe high are ignored
    wr_n = 1'b1; @(negedge clk);
    send_byte(8'h81);
    chk("R3 chain frozen", int'(chain_q), 'h3C5A);
    wr_n = 1'b0; @(negedge clk);

    // R8: strobe rises in the same cycle as a shift request
    send_byte(8'h77); sdi = 1'b1; send_byte(8'h4D);
    sdi = 1'b1; shift_en = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
    chk("R8 pre-edge payload", int'(grp_q[23:16]), 'h77);
    chk("R8 shift dropped", int'(chain_q), 'h774D);
    @(negedge clk); @(negedge clk);
    chk("R8 held strobe", int'(grp_q), 'h77A5FF);
    wr_n = 1'b0; @(negedge clk);
    chk("R9 tail", int'(tail_o), int'(chain_q[15]));

    rst = 1'b1; @(negedge clk);
    chk("R1 reset again", int'(grp_q), 0);
    rst = 1'b0; @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule